// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block sits beside a small microcontroller core and decides which of six interrupt sources is presented to the CPU. Software gives each source a one-bit level (high or low) in a priority register. The block applies the per-source enables and a global enable to the request flags, then splits the live requests by level. Inside each level, a fixed polling order breaks ties.

The block raises a request to the CPU only when the best pending level can pre-empt the work already running. On acknowledge it latches a 3-bit index for the winning source and marks that level as in service. A return strobe from the CPU ends the innermost routine. A low-level routine can therefore be interrupted once by a high-level one, for a nesting depth of two. A running routine is never interrupted by a request of its own level or a lower one.

Two sources are shared. The serial source is the OR of a receive flag and a transmit flag. The timer 2 source is the OR of an overflow flag and an external reload flag. Each pair has one level bit, one enable and one index.

Top module: `prioIntCtrl`

## Requirements
- R1: After reset, the priority register reads 0x00, both in-service flags are 0, `intReq` is 0 and `vecIndex` is 0.
- R2: Writing a full byte stores bits 5:0 of the priority register. A single-bit write sets or clears bit `prioBitSel` to `prioBitVal` when `prioBitSel` is 0 to 5, and has no effect for 6 or 7. Read-back bits 7:6 are always 0. Bit i of the register is the level of source i, with 1 meaning high. A full write takes precedence over a single-bit write in the same cycle.
- R3: The `rawReq` bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial receive, bit 5 timer 2 overflow, bit 6 serial transmit, bit 7 timer 2 reload. Source 4 is bit 4 OR bit 6, and source 5 is bit 5 OR bit 7. A source takes part only when its `srcEnable` bit and `globalEnable` are both 1.
- R4: `intReq` is 1 exactly when either of these holds: a participating high-level source is pending and the high level is not in service, or a participating low-level source is pending and neither level is in service. This is a combinational function of the current inputs and state.
- R5: The winner is the lowest-numbered pending high-level source if one exists, otherwise the lowest-numbered pending low-level source. Source numbers are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. An accepted acknowledge (`intAck` while `intReq` is 1) loads the winner's number into `vecIndex` in the following cycle.
- R6: `vecIndex` keeps its value in every cycle that has no accepted acknowledge. An `intAck` while `intReq` is 0 changes neither `vecIndex` nor the in-service flags.
- R7: An accepted acknowledge sets `hiInService` when the winner is at high level, and sets `loInService` otherwise.
- R8: `intRet` clears `hiInService` when it is set, leaving `loInService` unchanged. When `hiInService` is clear, `intRet` clears `loInService`.
- R9: While only the low level is in service, a pending high-level source raises `intReq`, and low-level requests do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawReq | input | 8 | Raw interrupt flags, layout per R3 |
| srcEnable | input | 6 | Per-source enable, indexed by source number |
| globalEnable | input | 1 | Master enable for all sources |
| prioWrEn | input | 1 | Full-byte write strobe for the priority register |
| prioWrData | input | 8 | Full-byte write data |
| prioBitWr | input | 1 | Single-bit write strobe |
| prioBitSel | input | 3 | Bit number for a single-bit write |
| prioBitVal | input | 1 | Value for a single-bit write |
| prioRdData | output | 8 | Priority register read-back, bits 7:6 always 0 |
| intAck | input | 1 | CPU acknowledge of the current request |
| intRet | input | 1 | CPU return-from-interrupt strobe |
| intReq | output | 1 | Interrupt request to the CPU |
| vecIndex | output | 3 | Number of the source taken at the last accepted acknowledge |
| hiInService | output | 1 | High-level routine in progress |
| loInService | output | 1 | Low-level routine in progress |

## Verification
A wrong in-service flag appears at `intReq` in the same cycle. A request that should pre-empt stays silent, or a request of the same level breaks into a routine. The sweep walks every level setting against every pending-source pattern from idle and checks the level flag after each acknowledge. A bad tie-break or level split therefore shows up as a wrong `vecIndex` or a wrong flag one cycle after that acknowledge. Directed nesting sequences check return order and blocking, where an error appears only after a second acknowledge or a return.

// File: rtl/prioIntPkg.sv
package prioIntPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic captureVec;  // latch the winner index this cycle
    logic selHigh;     // take the winner from the high level
  } ctrlStrobe_t;

  // summary from datapath to control
  typedef struct packed {
    logic hiAny;       // some participating high-level source pending
    logic loAny;       // some participating low-level source pending
  } dpStatus_t;

endpackage

// File: rtl/prioIntDatapath.sv
module prioIntDatapath
  import prioIntPkg::*;
#(
  parameter int NUM_SRC      = 6,
  parameter int FIRST_SHARED = 4,
  parameter int PRIO_W       = 8,
  parameter int VEC_W        = $clog2(NUM_SRC),
  parameter int SEL_W        = $clog2(PRIO_W),
  parameter int RAW_W        = NUM_SRC + (NUM_SRC - FIRST_SHARED)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RAW_W-1:0]   rawReq,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               globalEnable,
  input  logic               prioWrEn,
  input  logic [PRIO_W-1:0]  prioWrData,
  input  logic               prioBitWr,
  input  logic [SEL_W-1:0]   prioBitSel,
  input  logic               prioBitVal,
  input  ctrlStrobe_t        strobes,
  output dpStatus_t          status,
  output logic [PRIO_W-1:0]  prioRdData,
  output logic [VEC_W-1:0]   vecIndex
);

  localparam int RSV_W = PRIO_W - NUM_SRC;
  localparam logic [PRIO_W-1:0] LIVE_MASK = {{RSV_W{1'b0}}, {NUM_SRC{1'b1}}};

  logic [NUM_SRC-1:0] srcRaw;
  logic [NUM_SRC-1:0] srcLive;
  logic [NUM_SRC-1:0] prioLvl;
  logic [NUM_SRC-1:0] hiPend;
  logic [NUM_SRC-1:0] loPend;
  logic [VEC_W-1:0]   hiWin;
  logic [VEC_W-1:0]   loWin;

  // merge shared flag pairs into their source
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g >= FIRST_SHARED) begin : g_pair
      assign srcRaw[g] = rawReq[g] | rawReq[NUM_SRC + g - FIRST_SHARED];
    end else begin : g_single
      assign srcRaw[g] = rawReq[g];
    end
  end

  assign srcLive = srcRaw & srcEnable & {NUM_SRC{globalEnable}};
  assign hiPend  = srcLive & prioLvl;
  assign loPend  = srcLive & ~prioLvl;

  function automatic logic [VEC_W-1:0] firstSet(input logic [NUM_SRC-1:0] v);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) idx = VEC_W'(i);
    end
    return idx;
  endfunction

  assign hiWin        = firstSet(hiPend);
  assign loWin        = firstSet(loPend);
  assign status.hiAny = |hiPend;
  assign status.loAny = |loPend;

  // priority level register, reserved bits are not stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioLvl <= '0;
    end else if (prioWrEn) begin
      prioLvl <= prioWrData[NUM_SRC-1:0];
    end else if (prioBitWr && (int'(prioBitSel) < NUM_SRC)) begin
      prioLvl[prioBitSel] <= prioBitVal;
    end
  end

  assign prioRdData = {{RSV_W{1'b0}}, prioLvl};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecIndex <= '0;
    end else if (strobes.captureVec) begin
      vecIndex <= strobes.selHigh ? hiWin : loWin;
    end
  end

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureVec |=> $stable(vecIndex));

  // R2
  prio_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    prioWrEn |=> prioRdData == ($past(prioWrData) & LIVE_MASK));

  // R5
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(vecIndex) < NUM_SRC);

endmodule

// File: rtl/prioIntControl.sv
module prioIntControl
  import prioIntPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic        intAck,
  input  logic        intRet,
  output ctrlStrobe_t strobes,
  output logic        intReq,
  output logic        hiInService,
  output logic        loInService
);

  logic hiGo;
  logic loGo;
  logic accept;
  logic ackHi;
  logic ackLo;
  logic retHi;
  logic retLo;

  assign hiGo   = status.hiAny & ~hiInService;
  assign loGo   = status.loAny & ~hiInService & ~loInService;
  assign intReq = hiGo | loGo;

  assign accept = intAck & intReq;
  assign ackHi  = accept & status.hiAny;
  assign ackLo  = accept & ~status.hiAny;
  assign retHi  = intRet & hiInService;
  assign retLo  = intRet & ~hiInService & loInService;

  assign strobes.captureVec = accept;
  assign strobes.selHigh    = status.hiAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiInService <= 1'b0;
      loInService <= 1'b0;
    end else begin
      hiInService <= (hiInService & ~retHi) | ackHi;
      loInService <= (loInService & ~retLo) | ackLo;
    end
  end

  // R4
  hi_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiInService |-> !intReq);

  // R7
  ack_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq && status.hiAny) |=> hiInService);

  // R8
  ret_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intRet && hiInService && !intAck) |=> (!hiInService && $stable(loInService)));

  // R9
  lo_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loInService && !hiInService && !status.hiAny) |-> !intReq);

endmodule

// File: rtl/prioIntCtrl.sv
module prioIntCtrl
  import prioIntPkg::*;
#(
  parameter int NUM_SRC      = 6,
  parameter int FIRST_SHARED = 4,
  parameter int PRIO_W       = 8,
  parameter int VEC_W        = $clog2(NUM_SRC),
  parameter int SEL_W        = $clog2(PRIO_W),
  parameter int RAW_W        = NUM_SRC + (NUM_SRC - FIRST_SHARED)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RAW_W-1:0]   rawReq,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               globalEnable,
  input  logic               prioWrEn,
  input  logic [PRIO_W-1:0]  prioWrData,
  input  logic               prioBitWr,
  input  logic [SEL_W-1:0]   prioBitSel,
  input  logic               prioBitVal,
  output logic [PRIO_W-1:0]  prioRdData,
  input  logic               intAck,
  input  logic               intRet,
  output logic               intReq,
  output logic [VEC_W-1:0]   vecIndex,
  output logic               hiInService,
  output logic               loInService
);

  ctrlStrobe_t strobes;
  dpStatus_t   status;

  prioIntDatapath #(
    .NUM_SRC(NUM_SRC), .FIRST_SHARED(FIRST_SHARED), .PRIO_W(PRIO_W),
    .VEC_W(VEC_W), .SEL_W(SEL_W), .RAW_W(RAW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rawReq(rawReq), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .prioWrEn(prioWrEn), .prioWrData(prioWrData),
    .prioBitWr(prioBitWr), .prioBitSel(prioBitSel), .prioBitVal(prioBitVal),
    .strobes(strobes), .status(status), .prioRdData(prioRdData),
    .vecIndex(vecIndex)
  );

  prioIntControl u_ctl (
    .clk(clk), .rstN(rstN), .status(status), .intAck(intAck), .intRet(intRet),
    .strobes(strobes), .intReq(intReq), .hiInService(hiInService),
    .loInService(loInService)
  );

endmodule

// File: tb/prioIntCtrl_tb.sv
`timescale 1ns/1ps
module prioIntCtrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rawReq = '0;
  logic [5:0] srcEnable = '0;
  logic       globalEnable = 1'b0;
  logic       prioWrEn = 1'b0;
  logic [7:0] prioWrData = '0;
  logic       prioBitWr = 1'b0;
  logic [2:0] prioBitSel = '0;
  logic       prioBitVal = 1'b0;
  logic [7:0] prioRdData;
  logic       intAck = 1'b0;
  logic       intRet = 1'b0;
  logic       intReq;
  logic [2:0] vecIndex;
  logic       hiInService;
  logic       loInService;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  prioIntCtrl u_dut (
    .clk(clk), .rstN(rstN), .rawReq(rawReq), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .prioWrEn(prioWrEn), .prioWrData(prioWrData),
    .prioBitWr(prioBitWr), .prioBitSel(prioBitSel), .prioBitVal(prioBitVal),
    .prioRdData(prioRdData), .intAck(intAck), .intRet(intRet), .intReq(intReq),
    .vecIndex(vecIndex), .hiInService(hiInService), .loInService(loInService)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // state word: {intReq, hi, lo, vec}
  function automatic int stateWord();
    return {26'd0, intReq, hiInService, loInService, vecIndex};
  endfunction

  function automatic int lowest(input int v);
    for (int i = 0; i < 6; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic writePrio(input logic [7:0] d);
    @(negedge clk); prioWrEn = 1'b1; prioWrData = d;
    @(negedge clk); prioWrEn = 1'b0;
  endtask

  task automatic bitPrio(input int sel, input bit val);
    @(negedge clk); prioBitWr = 1'b1; prioBitSel = 3'(sel); prioBitVal = val;
    @(negedge clk); prioBitWr = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    #0.5;
  endtask

  task automatic pulseRet();
    @(negedge clk); intRet = 1'b1;
    @(negedge clk); intRet = 1'b0;
    #0.5;
  endtask

  initial begin
    #800000;
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int sv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R1
    check(prioRdData == 8'h00 && stateWord() == 0, "R1", "reset state",
          {prioRdData, 8'(stateWord())}, 0);

    // R2 full write, reserved bits dropped
    writePrio(8'hFF); #0.5;
    check(prioRdData == 8'h3F, "R2", "full write 0xFF", prioRdData, 8'h3F);
    bitPrio(6, 1'b1); #0.5;
    check(prioRdData == 8'h3F, "R2", "bit write 6 ignored", prioRdData, 8'h3F);
    bitPrio(2, 1'b0); #0.5;
    check(prioRdData == 8'h3B, "R2", "bit write 2 clear", prioRdData, 8'h3B);
    writePrio(8'hC0); #0.5;
    check(prioRdData == 8'h00, "R2", "full write 0xC0", prioRdData, 8'h00);
    bitPrio(5, 1'b1); #0.5;
    check(prioRdData == 8'h20, "R2", "bit write 5 set", prioRdData, 8'h20);
    writePrio(8'h00);

    // R3 shared pairs and enables
    srcEnable = 6'h3F; globalEnable = 1'b1;
    @(negedge clk); rawReq = 8'h40; #0.5;
    check(intReq == 1'b1, "R3", "serial transmit raises request", intReq, 1);
    pulseAck();
    check(vecIndex == 3'd4 && loInService, "R3", "serial transmit index", vecIndex, 4);
    @(negedge clk); rawReq = 8'h00; pulseRet();
    @(negedge clk); rawReq = 8'h80; #0.5;
    pulseAck();
    check(vecIndex == 3'd5, "R3", "timer 2 reload index", vecIndex, 5);
    @(negedge clk); rawReq = 8'h00; pulseRet();
    @(negedge clk); rawReq = 8'h40; srcEnable = 6'h2F; #0.5;
    check(intReq == 1'b0, "R3", "disabled serial source", intReq, 0);
    @(negedge clk); rawReq = 8'hFF; srcEnable = 6'h3F; globalEnable = 1'b0; #0.5;
    check(intReq == 1'b0, "R3", "global enable off", intReq, 0);
    @(negedge clk); rawReq = 8'h00; globalEnable = 1'b1;

    // R6 ack with no request
    @(negedge clk); sv = stateWord();
    pulseAck();
    check(stateWord() == sv, "R6", "ack ignored when idle", stateWord(), sv);

    // R4 R5 R7 R8 sweep over all levels and pending patterns
    for (int p = 0; p < 64; p++) begin
      for (int s = 1; s < 64; s++) begin
        int hp;
        int expVec;
        bit expHi;
        bit ok;
        hp = s & p;
        expHi = (hp != 0);
        expVec = expHi ? lowest(hp) : lowest(s);
        @(negedge clk); prioWrEn = 1'b1; prioWrData = 8'(p); rawReq = 8'(s);
        @(negedge clk); prioWrEn = 1'b0; #0.5;
        ok = (intReq == 1'b1);
        intAck = 1'b1;
        @(negedge clk); intAck = 1'b0; #0.5;
        ok = ok && (int'(vecIndex) == expVec) && (hiInService == expHi) &&
             (loInService == !expHi) && (intReq == (!expHi && (hp != 0)));
        if (!ok)
          check(1'b0, "R5", $sformatf("sweep p=%0h s=%0h", p, s),
                stateWord(), {27'd0, !expHi && hp != 0, expHi, !expHi, 3'(expVec)});
        intRet = 1'b1; rawReq = 8'h00;
        @(negedge clk); intRet = 1'b0; #0.5;
        ok = !hiInService && !loInService;
        check(ok, "R8", $sformatf("sweep return p=%0h s=%0h", p, s),
              {hiInService, loInService}, 0);
      end
    end

    // R9 nesting: timer 0 high, others low
    writePrio(8'h02);
    @(negedge clk); rawReq = 8'h01; pulseAck();
    check(loInService && !hiInService && vecIndex == 3'd0, "R7", "low ack sets low flag",
          stateWord(), 32'h00000008);
    @(negedge clk); rawReq = 8'h05; #0.5;
    check(intReq == 1'b0, "R9", "low request blocked by low service", intReq, 0);
    @(negedge clk); rawReq = 8'h07; #0.5;
    check(intReq == 1'b1, "R9", "high request pre-empts low service", intReq, 1);
    pulseAck();
    check(hiInService && loInService && vecIndex == 3'd1, "R9", "nested high ack",
          stateWord(), 32'h00000019);
    @(negedge clk); writePrio(8'h06); #0.5;
    check(intReq == 1'b0, "R4", "high request blocked by high service", intReq, 0);
    check(vecIndex == 3'd1, "R6", "index held without ack", vecIndex, 1);
    pulseRet();
    check(!hiInService && loInService, "R8", "return clears high first",
          {hiInService, loInService}, 1);
    check(intReq == 1'b1, "R4", "high pending after high return", intReq, 1);
    @(negedge clk); rawReq = 8'h00; pulseRet();
    check(!hiInService && !loInService, "R8", "second return clears low",
          {hiInService, loInService}, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule